// File: doc/BRIEF.md
# UART Status Flag and Interrupt Controller

This block keeps the four status flags of a FIFO-buffered UART and combines them into one interrupt request. It sits between the UART datapath and the register bus. It watches level and pulse inputs from the transmit FIFO, the receive FIFO, the transmit shifter, the line-idle detector and the mute controller. It also sees three bus strobes: a data-register write, a clear-flag write and a request write.

The flags are transmit-space-available, transmit-finished, receive-data-available and line-idle. Each one is a register that follows its own set, clear and hold rules, and the rules interact. A transmit flush holds the space flag low until the FIFO drains. A data write retires the transmit-finished flag. The idle flag is re-armed only by fresh receive data and is blocked while the receiver is muted. Every pin is a plain control or status level. No data stream crosses this block, so no valid/ready handshake and no back-pressure apply.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset, `txnf_o`=1, `tc_o`=1, `rxne_o`=0, `idle_o`=0 and `irq_o`=0, and the idle re-arm state is armed.
- R2: Outside a flush, `txnf_o` takes the value of `!txf_full_i` on the next clock edge.
- R3: A request write with `req_txflush_i`=1 holds `txnf_o` at 0 from the next edge on, until the edge after `txf_empty_i`=1 is seen. At that edge `txnf_o` returns to 1.
- R4: `tc_o` becomes 1 on the edge after a cycle where `tx_frame_done_i`=1 and `txf_empty_i`=1.
- R5: `tc_o` becomes 0 on the edge after `dr_wr_i`=1, or after `clr_wr_i`=1 with `clr_tc_i`=1. A set condition (R4 or R6) in the same cycle wins over the clear.
- R6: When `tx_en_i`=0 and `tx_busy_i`=0, `tc_o` is 1 on the next edge.
- R7: `rxne_o` takes the value of `!rxf_empty_i` on the next edge. A request write with `req_rxflush_i`=1 forces it to 0 on the next edge.
- R8: `idle_o` sets on the edge after an accepted idle detection. Only a clear write with `clr_idle_i`=1 resets it. An accepted detection in the same cycle wins over the clear.
- R9: An idle detection is accepted only while the re-arm state is armed. Acceptance disarms it, and it is re-armed only on an edge where `rxne_o` goes from 0 to 1.
- R10: While `mute_en_i`=1 and `rx_muted_i`=1, idle detections are ignored and do not disarm. With `mute_en_i`=1 and `rx_muted_i`=0 they are accepted as usual.
- R11: `irq_o` is registered. It equals the OR, over the flags as they stood before the edge, of each flag ANDed with its enable bit. The bit order of `irq_en_i` is [0] txnf, [1] tc, [2] rxne, [3] idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txf_full_i | input | 1 | Transmit FIFO full |
| txf_empty_i | input | 1 | Transmit FIFO empty |
| rxf_empty_i | input | 1 | Receive FIFO empty |
| tx_frame_done_i | input | 1 | Pulse: a data frame finished shifting out |
| tx_busy_i | input | 1 | A frame is in progress in the shifter |
| tx_en_i | input | 1 | Transmitter enable |
| idle_det_i | input | 1 | Pulse: idle line detected |
| mute_en_i | input | 1 | Mute mode enabled |
| rx_muted_i | input | 1 | Receiver currently muted |
| dr_wr_i | input | 1 | Bus write to the transmit data register |
| clr_wr_i | input | 1 | Bus write to the clear-flag register |
| clr_tc_i | input | 1 | Clear bit for the transmit-finished flag |
| clr_idle_i | input | 1 | Clear bit for the idle flag |
| req_wr_i | input | 1 | Bus write to the request register |
| req_txflush_i | input | 1 | Transmit flush request bit |
| req_rxflush_i | input | 1 | Receive flush request bit |
| irq_en_i | input | 4 | Per-flag interrupt enables |
| txnf_o | output | 1 | Transmit FIFO has a free slot |
| tc_o | output | 1 | Transmission complete |
| rxne_o | output | 1 | Receive data available |
| idle_o | output | 1 | Idle line flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The functions that can fall in the same cycle are a flag's set event and the bus clear of that same flag. This happens with a frame-done plus data write or clear bit on `tc_o`, and with an idle detection plus the idle clear bit on `idle_o`. Directed steps drive each pair on one cycle, with the idle re-arm set up first. The random phase raises strobes and events often enough that they overlap many times. A behavioural model in the bench gives the event priority and is compared with every output on every clock.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int NFLAGS = 4;
  typedef enum int unsigned {
    FLG_TXNF = 0,
    FLG_TC   = 1,
    FLG_RXNE = 2,
    FLG_IDLE = 3
  } flag_idx_e;
  typedef logic [NFLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic txf_full_i,
  input  logic txf_empty_i,
  input  logic tx_frame_done_i,
  input  logic tx_busy_i,
  input  logic tx_en_i,
  input  logic dr_wr_i,
  input  logic tc_clr_i,
  input  logic flush_req_i,
  output logic txnf_o,
  output logic tc_o
);
  logic flush_q, flush_d, hold_low;
  logic txnf_d, tc_d, tc_set, tc_clr;

  assign hold_low = flush_q | flush_req_i;

  always_comb begin
    flush_d = hold_low & ~txf_empty_i;
    if (txf_empty_i)   txnf_d = 1'b1;
    else if (hold_low) txnf_d = 1'b0;
    else               txnf_d = ~txf_full_i;
  end

  assign tc_set = (tx_frame_done_i & txf_empty_i) | (~tx_en_i & ~tx_busy_i);
  assign tc_clr = dr_wr_i | tc_clr_i;

  always_comb begin
    if (tc_set)      tc_d = 1'b1;
    else if (tc_clr) tc_d = 1'b0;
    else             tc_d = tc_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      txnf_o  <= 1'b1;
      tc_o    <= 1'b1;
    end else begin
      flush_q <= flush_d;
      txnf_o  <= txnf_d;
      tc_o    <= tc_d;
    end
  end

  AST_TXNF_FULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_full_i && !txf_empty_i) |=> !txnf_o); // R2
  AST_TXNF_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req_i && !txf_empty_i) |=> !txnf_o); // R3
  AST_TC_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en_i && !tx_busy_i) |=> tc_o); // R6
  AST_TC_DR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_wr_i && !(tx_frame_done_i && txf_empty_i) && (tx_en_i || tx_busy_i)) |=> !tc_o); // R5
  AST_TC_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_frame_done_i && txf_empty_i) |=> tc_o); // R4
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic rxf_empty_i,
  input  logic flush_req_i,
  input  logic idle_det_i,
  input  logic mute_en_i,
  input  logic rx_muted_i,
  input  logic idle_clr_i,
  output logic rxne_o,
  output logic idle_o
);
  logic rxne_d, rxne_rise, arm_q, arm_d, idle_d, idle_take, muted;

  assign rxne_d    = flush_req_i ? 1'b0 : ~rxf_empty_i;
  assign rxne_rise = rxne_d & ~rxne_o;
  assign muted     = mute_en_i & rx_muted_i;
  assign idle_take = idle_det_i & arm_q & ~muted;

  always_comb begin
    if (rxne_rise)      arm_d = 1'b1;
    else if (idle_take) arm_d = 1'b0;
    else                arm_d = arm_q;
    if (idle_take)       idle_d = 1'b1;
    else if (idle_clr_i) idle_d = 1'b0;
    else                 idle_d = idle_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxne_o <= 1'b0;
      idle_o <= 1'b0;
      arm_q  <= 1'b1;
    end else begin
      rxne_o <= rxne_d;
      idle_o <= idle_d;
      arm_q  <= arm_d;
    end
  end

  AST_RXNE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req_i |=> !rxne_o); // R7
  AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && !idle_clr_i) |=> idle_o); // R8
  AST_IDLE_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_en_i && rx_muted_i && !idle_o) |=> !idle_o); // R10
  AST_IDLE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_take && !rxne_rise) |=> !arm_q); // R9
endmodule

// File: rtl/uart_irq_combine.sv
module uart_irq_combine
  import uart_flag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t flags_i,
  input  flag_vec_t en_i,
  output logic      irq_o
);
  flag_vec_t masked;
  logic      any;

  generate
    for (genvar g = 0; g < NFLAGS; g++) begin : g_mask
      assign masked[g] = flags_i[g] & en_i[g];
    end
  endgenerate

  assign any = |masked;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= any;
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !irq_o); // R11
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i & en_i) != '0) |=> irq_o); // R11
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txf_full_i,
  input  logic              txf_empty_i,
  input  logic              rxf_empty_i,
  input  logic              tx_frame_done_i,
  input  logic              tx_busy_i,
  input  logic              tx_en_i,
  input  logic              idle_det_i,
  input  logic              mute_en_i,
  input  logic              rx_muted_i,
  input  logic              dr_wr_i,
  input  logic              clr_wr_i,
  input  logic              clr_tc_i,
  input  logic              clr_idle_i,
  input  logic              req_wr_i,
  input  logic              req_txflush_i,
  input  logic              req_rxflush_i,
  input  logic [NFLAGS-1:0] irq_en_i,
  output logic              txnf_o,
  output logic              tc_o,
  output logic              rxne_o,
  output logic              idle_o,
  output logic              irq_o
);
  flag_vec_t flags;

  uart_tx_flags u_tx (
    .clk, .rst_n, .txf_full_i, .txf_empty_i, .tx_frame_done_i,
    .tx_busy_i, .tx_en_i, .dr_wr_i,
    .tc_clr_i    (clr_wr_i & clr_tc_i),
    .flush_req_i (req_wr_i & req_txflush_i),
    .txnf_o, .tc_o
  );

  uart_rx_flags u_rx (
    .clk, .rst_n, .rxf_empty_i,
    .flush_req_i (req_wr_i & req_rxflush_i),
    .idle_det_i, .mute_en_i, .rx_muted_i,
    .idle_clr_i  (clr_wr_i & clr_idle_i),
    .rxne_o, .idle_o
  );

  always_comb begin
    flags           = '0;
    flags[FLG_TXNF] = txnf_o;
    flags[FLG_TC]   = tc_o;
    flags[FLG_RXNE] = rxne_o;
    flags[FLG_IDLE] = idle_o;
  end

  uart_irq_combine u_irq (
    .clk, .rst_n, .flags_i(flags), .en_i(irq_en_i), .irq_o
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (txnf_o && tc_o && !rxne_o && !idle_o && !irq_o)); // R1
endmodule

// File: tb/tb_uart_flag_ctrl.sv
module tb_uart_flag_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic txf_full = 0, txf_empty = 0, rxf_empty = 1, done = 0, busy = 0, ten = 0;
  logic idet = 0, men = 0, muted = 0, drw = 0, clrw = 0, ctc = 0, cidle = 0;
  logic reqw = 0, rtx = 0, rrx = 0;
  logic [3:0] ien = 0;
  logic txnf, tc, rxne, idle, irq;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0, cmp_on = 0;
  bit m_txnf, m_tc, m_rxne, m_idle, m_irq, m_fl, m_arm;

  always #5 clk = ~clk;

  uart_flag_ctrl dut (
    .clk, .rst_n, .txf_full_i(txf_full), .txf_empty_i(txf_empty), .rxf_empty_i(rxf_empty),
    .tx_frame_done_i(done), .tx_busy_i(busy), .tx_en_i(ten), .idle_det_i(idet),
    .mute_en_i(men), .rx_muted_i(muted), .dr_wr_i(drw), .clr_wr_i(clrw),
    .clr_tc_i(ctc), .clr_idle_i(cidle), .req_wr_i(reqw), .req_txflush_i(rtx),
    .req_rxflush_i(rrx), .irq_en_i(ien), .txnf_o(txnf), .tc_o(tc), .rxne_o(rxne),
    .idle_o(idle), .irq_o(irq)
  );

  // Behavioural reference: next values from the rules, evaluated at each edge.
  always @(posedge clk) begin
    bit n_rxne, take, hold;
    if (!rst_n) begin
      m_txnf = 1; m_tc = 1; m_rxne = 0; m_idle = 0; m_irq = 0; m_fl = 0; m_arm = 1;
    end else begin
      m_irq = (ien[0] && m_txnf) || (ien[1] && m_tc) || (ien[2] && m_rxne) || (ien[3] && m_idle);
      hold = m_fl || (reqw && rtx);
      m_fl = hold && !txf_empty;
      m_txnf = txf_empty ? 1 : (hold ? 0 : !txf_full);
      if ((done && txf_empty) || (!ten && !busy)) m_tc = 1;
      else if (drw || (clrw && ctc)) m_tc = 0;
      n_rxne = (reqw && rrx) ? 0 : !rxf_empty;
      take = idet && m_arm && !(men && muted);
      if (n_rxne && !m_rxne) m_arm = 1;
      else if (take) m_arm = 0;
      m_rxne = n_rxne;
      if (take) m_idle = 1;
      else if (clrw && cidle) m_idle = 0;
    end
  end

  task automatic cmp(string tag, bit act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on && rst_n) begin
    cmp("R2/R3 txnf model", txnf, m_txnf);
    cmp("R4/R5/R6 tc model", tc, m_tc);
    cmp("R7 rxne model", rxne, m_rxne);
    cmp("R8/R9/R10 idle model", idle, m_idle);
    cmp("R11 irq model", irq, m_irq);
  end

  task automatic step(); @(posedge clk); #1; endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1; cmp_on = 1;
    #0;
    cmp("R1 txnf", txnf, 1); cmp("R1 tc", tc, 1); cmp("R1 rxne", rxne, 0);
    cmp("R1 idle", idle, 0); cmp("R1 irq", irq, 0);
    ten = 1; busy = 1; step();
    cmp("R2 txnf mid", txnf, 1);
    txf_full = 1; step(); cmp("R2 txnf full", txnf, 0); txf_full = 0;
    drw = 1; step(); drw = 0; cmp("R5 tc data write", tc, 0);
    reqw = 1; rtx = 1; step(); reqw = 0; rtx = 0; cmp("R3 flush low", txnf, 0);
    step(); cmp("R3 flush still low", txnf, 0);
    txf_empty = 1; step(); cmp("R3 flush drained", txnf, 1);
    done = 1; step(); done = 0; cmp("R4 tc set", tc, 1);
    clrw = 1; ctc = 1; done = 1; step(); done = 0; cmp("R5 set beats clear", tc, 1);
    step(); clrw = 0; ctc = 0; cmp("R5 clear bit", tc, 0);
    ten = 0; busy = 0; step(); cmp("R6 forced", tc, 1); ten = 1; busy = 1;
    rxf_empty = 0; step(); cmp("R7 rxne set", rxne, 1);
    reqw = 1; rrx = 1; step(); reqw = 0; rrx = 0; rxf_empty = 1; cmp("R7 rx flush", rxne, 0);
    idet = 1; step(); idet = 0; cmp("R8 idle set", idle, 1);
    step(); cmp("R8 idle sticky", idle, 1);
    clrw = 1; cidle = 1; step(); clrw = 0; cidle = 0; cmp("R8 idle clear", idle, 0);
    idet = 1; step(); idet = 0; cmp("R9 not rearmed", idle, 0);
    rxf_empty = 0; step(); rxf_empty = 1; step();
    idet = 1; clrw = 1; cidle = 1; step(); idet = 0; clrw = 0; cidle = 0;
    cmp("R9 rearmed, R8 event beats clear", idle, 1);
    clrw = 1; cidle = 1; rxf_empty = 0; step(); clrw = 0; cidle = 0; rxf_empty = 1; step();
    men = 1; muted = 1; idet = 1; step(); cmp("R10 muted ignored", idle, 0);
    muted = 0; step(); idet = 0; cmp("R10 unmuted accepted", idle, 1);
    ien = 4'b1000; step(); cmp("R11 idle enabled", irq, 1);
    ien = 4'b0000; step(); cmp("R11 all masked", irq, 0);
    men = 0;
    for (int i = 0; i < 4000; i++) begin
      int lv;
      lv = $urandom_range(0, 2);
      txf_empty = (lv == 0); txf_full = (lv == 2);
      rxf_empty = ($urandom_range(0, 9) < 6);
      done = ($urandom_range(0, 4) == 0); busy = ($urandom_range(0, 2) != 0);
      ten = ($urandom_range(0, 5) != 0); idet = ($urandom_range(0, 3) == 0);
      men = $urandom_range(0, 1); muted = $urandom_range(0, 1);
      drw = ($urandom_range(0, 7) == 0); clrw = ($urandom_range(0, 3) == 0);
      ctc = $urandom_range(0, 1); cidle = $urandom_range(0, 1);
      reqw = ($urandom_range(0, 9) == 0); rtx = $urandom_range(0, 1); rrx = $urandom_range(0, 1);
      ien = 4'($urandom_range(0, 15));
      if (i == 2000) rst_n = 0;
      if (i == 2002) rst_n = 1;
      step();
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule